// File: doc/BRIEF.md
# Daisy-Chained Converter Readback Controller

This block is the host side of a three-wire link to a chain of serial 16-bit converters. The converters are wired output-to-input, and the input of the far device is tied low. On a start pulse the controller raises the convert line while the serial clock is low. That low clock at the convert edge puts the converters into chained readback. The controller then waits a fixed number of clock cycles for the conversion to finish. Next it toggles the serial clock once for every bit of every device, with the convert line still high.

The controller samples the serial data line at each falling edge of the serial clock. It packs the bits, most significant first, into one word per converter. The word from the device wired straight to the host arrives first, followed by the words of the devices further up the chain. Each word leaves on a valid/ready stream together with its position in the chain. After the last bit the convert line drops and the serial clock stays low. A busy flag covers the whole transaction, including the time until the final word is taken.

Back-pressure on the stream: a word stays on the output, unchanged, until ready is seen with valid. The controller has a single output register. When the next word is one falling edge from completion and the previous word has not been taken, the serial clock is held high. That edge is delayed until the consumer accepts. The data line stays valid while the clock is held, so no bit is lost.

Top module: `chain_rd_ctrl`

## Requirements
- R1: While reset is asserted and right after it, busy, convert, serial clock and word valid are all low.
- R2: A start pulse seen while idle raises convert and busy at the next clock edge. The serial clock is low when convert rises.
- R3: The first serial clock rising edge comes exactly CONV_CYC + SCK_DIV clock cycles after convert rises. Without back-pressure, each serial clock phase lasts SCK_DIV cycles, so convert stays high for CONV_CYC + 2·SCK_DIV·WORD_W·NUM_DEV cycles.
- R4: Each transaction has exactly WORD_W·NUM_DEV serial clock rising edges. The serial clock is high only while convert is high.
- R5: The data line is sampled at each serial clock falling edge, and words are built most significant bit first. The word with index 0 is the one from the device that drives the host. Each later word has an index one higher and comes from the next device upstream.
- R6: While valid is high and ready is low, valid, data and index hold steady. If the word that is still waiting blocks the falling edge that completes the next word, the serial clock stays high until the consumer accepts.
- R7: After the last falling edge, convert is low and the serial clock stays low. Busy stays high until the last word has been accepted, then falls.
- R8: A start pulse during a transaction is ignored. Convert rises only once per transaction and no extra serial clocks appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a conversion and readback |
| busy_o | output | 1 | High from start until the last word is accepted |
| cnv_o | output | 1 | Convert line to all chained devices |
| sck_o | output | 1 | Serial clock to all chained devices |
| sdo_i | input | 1 | Serial data from the device nearest the host |
| word_data_o | output | WORD_W | Assembled converter word |
| word_idx_o | output | IDX_W | Chain position of the word, 0 = nearest the host |
| word_valid_o | output | 1 | Word present on the stream |
| word_ready_i | input | 1 | Consumer accepts the word |

## Verification
Two things can happen on the same edge. The output register can hand one word to the consumer and load the next word from the final falling edge of the serial clock. Separately, a held falling edge can be released by the same ready that empties the register. To provoke the first, ready is asserted only on every third cycle, so acceptance sometimes lines up with word completion and sometimes comes before it. To provoke the second, ready is kept low for a long stretch on the first word: the bench confirms that the serial clock is parked high after exactly two words' worth of rising edges and that the waiting data is unchanged. In both cases every received word and index is compared with the pattern loaded into a model of the chain.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/chain_rd_sck_gen.sv
module chain_rd_sck_gen #(
  parameter int SCK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic hold_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int DIV_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_DIV - 1);

  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             at_end;

  assign at_end = (cnt_q == DIV_LAST);
  // A falling edge happens at this clock edge: the sampling strobe.
  assign fall_o = run_i & sck_q & at_end & ~hold_i;
  assign sck_o  = sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (at_end) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        cnt_q <= '0;
      end else if (!hold_i) begin
        sck_q <= 1'b0;
        cnt_q <= '0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chain_rd_seq.sv
module chain_rd_seq
  import chain_rd_pkg::*;
#(
  parameter int NUM_DEV  = 3,
  parameter int WORD_W   = 16,
  parameter int CONV_CYC = 20,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fall_i,
  input  logic             take_i,
  output logic             run_o,
  output logic             cnv_o,
  output logic             busy_o,
  output logic             last_bit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int CONV_W = $clog2(CONV_CYC + 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NUM_DEV - 1);
  localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_CYC - 1);

  seq_state_e        state_q;
  logic [CONV_W-1:0] conv_q;
  logic [BIT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cnv_q;

  assign run_o      = (state_q == ST_SHIFT);
  assign busy_o     = (state_q != ST_IDLE);
  assign cnv_o      = cnv_q;
  assign last_bit_o = (bit_q == BIT_LAST);
  assign idx_o      = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      conv_q  <= '0;
      bit_q   <= '0;
      idx_q   <= '0;
      cnv_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CONV;
            conv_q  <= '0;
            bit_q   <= '0;
            idx_q   <= '0;
            cnv_q   <= 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_q == CONV_LAST) begin
            state_q <= ST_SHIFT;
          end else begin
            conv_q <= conv_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (fall_i) begin
            if (bit_q == BIT_LAST) begin
              bit_q <= '0;
              if (idx_q == IDX_LAST) begin
                state_q <= ST_DRAIN;
                cnv_q   <= 1'b0;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (take_i) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_rd_deser.sv
module chain_rd_deser #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              last_bit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sdo_i,
  input  logic              ready_i,
  output logic [WORD_W-1:0] data_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);
  logic [WORD_W-2:0] shreg_q;
  logic [WORD_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;
  logic              valid_q;

  assign data_o  = data_q;
  assign idx_o   = idx_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (fall_i && !last_bit_i) begin
        shreg_q <= {shreg_q[WORD_W-3:0], sdo_i};
      end
      if (fall_i && last_bit_i) begin
        data_q  <= {shreg_q, sdo_i};
        idx_q   <= idx_i;
        valid_q <= 1'b1;
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chain_rd_ctrl.sv
module chain_rd_ctrl #(
  parameter int NUM_DEV  = 3,
  parameter int WORD_W   = 16,
  parameter int SCK_DIV  = 2,
  parameter int CONV_CYC = 20,
  localparam int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              cnv_o,
  output logic              sck_o,
  input  logic              sdo_i,
  output logic [WORD_W-1:0] word_data_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              word_valid_o,
  input  logic              word_ready_i
);
  logic             run;
  logic             fall;
  logic             hold;
  logic             last_bit;
  logic             take;
  logic [IDX_W-1:0] cur_idx;

  // The falling edge that completes a word waits for a free output register.
  assign hold = last_bit & word_valid_o & ~word_ready_i;
  assign take = word_valid_o & word_ready_i;

  chain_rd_seq #(
    .NUM_DEV (NUM_DEV),
    .WORD_W  (WORD_W),
    .CONV_CYC(CONV_CYC),
    .IDX_W   (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .fall_i    (fall),
    .take_i    (take),
    .run_o     (run),
    .cnv_o     (cnv_o),
    .busy_o    (busy_o),
    .last_bit_o(last_bit),
    .idx_o     (cur_idx)
  );

  chain_rd_sck_gen #(
    .SCK_DIV(SCK_DIV)
  ) u_sck (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run),
    .hold_i(hold),
    .sck_o (sck_o),
    .fall_o(fall)
  );

  chain_rd_deser #(
    .WORD_W(WORD_W),
    .IDX_W (IDX_W)
  ) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_i    (fall),
    .last_bit_i(last_bit),
    .idx_i     (cur_idx),
    .sdo_i     (sdo_i),
    .ready_i   (word_ready_i),
    .data_o    (word_data_o),
    .idx_o     (word_idx_o),
    .valid_o   (word_valid_o)
  );
endmodule

// File: rtl/chain_rd_chk.sv
module chain_rd_chk #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              cnv_o,
  input logic              sck_o,
  input logic [WORD_W-1:0] word_data_o,
  input logic [IDX_W-1:0]  word_idx_o,
  input logic              word_valid_o,
  input logic              word_ready_i
);
  // R2: convert rises only with the serial clock low, and busy is high with it.
  a_r2_cnv_rise_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> (!sck_o && busy_o));

  // R4: the serial clock is high only inside the convert window.
  a_r4_sck_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> cnv_o);

  // R6: a waiting word holds still.
  a_r6_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !word_ready_i) |=>
      (word_valid_o && $stable(word_data_o) && $stable(word_idx_o)));

  // R7: when idle, all outputs of the link and the stream are quiet.
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cnv_o && !sck_o && !word_valid_o));

  // R8: convert rises only from the idle state.
  a_r8_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> !$past(busy_o));
endmodule

bind chain_rd_ctrl chain_rd_chk #(
  .WORD_W(WORD_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .cnv_o       (cnv_o),
  .sck_o       (sck_o),
  .word_data_o (word_data_o),
  .word_idx_o  (word_idx_o),
  .word_valid_o(word_valid_o),
  .word_ready_i(word_ready_i)
);

// File: tb/tb_chain_rd_ctrl.sv
`timescale 1ns/1ps
module tb_chain_rd_ctrl;
  localparam int NUM_DEV  = 3;
  localparam int WORD_W   = 16;
  localparam int SCK_DIV  = 2;
  localparam int CONV_CYC = 20;
  localparam int IDX_W    = 2;
  localparam int TOTAL    = NUM_DEV * WORD_W;
  localparam int STALL    = 150;
  localparam int WD_LIMIT = 100000;

  typedef struct packed {
    logic [TOTAL-1:0] words;
    logic [1:0]       mode;
  } vec_t;

  // words[TOTAL-1 -: 16] belongs to chain index 0 (device driving the host)
  localparam vec_t VECS [4] = '{
    '{48'hA5C3_0001_FFFF, 2'd0},
    '{48'h8000_7FFE_1234, 2'd1},
    '{48'h0000_FFFF_5A5A, 2'd2},
    '{48'hFFFF_0000_C001, 2'd1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              busy, cnv, sck, sdo;
  logic [WORD_W-1:0] wdata;
  logic [IDX_W-1:0]  widx;
  logic              wvalid;
  logic              rdy = 1'b1;

  chain_rd_ctrl #(
    .NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .SCK_DIV(SCK_DIV), .CONV_CYC(CONV_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .cnv_o(cnv),
    .sck_o(sck), .sdo_i(sdo), .word_data_o(wdata), .word_idx_o(widx),
    .word_valid_o(wvalid), .word_ready_i(rdy)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // ---- chain model: one long shift register, far end fed with zero ----
  logic [TOTAL-1:0] model_words = '0;
  logic [TOTAL-1:0] chain = '0;
  logic             cnv_seen = 1'b0;
  int               bad_start = 0;
  assign sdo = chain[TOTAL-1];

  always @(posedge cnv or negedge sck) begin
    if (cnv && !cnv_seen) begin
      if (sck) bad_start++;
      chain = model_words;
    end else begin
      #1 chain = {chain[TOTAL-2:0], 1'b0};
    end
    cnv_seen = cnv;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- monitor and ready driver ----
  logic [1:0]        mode = 2'd0;
  logic              rel = 1'b0;
  int                cyc = 0;
  int                rises = 0, cnv_rises = 0, cnv_hi = 0, lat = 0, bad_sck = 0;
  int                stall_cnt = 0, slot = 0;
  logic              prev_sck = 1'b0, prev_cnv = 1'b0;
  logic [WORD_W-1:0] got_d [NUM_DEV];
  logic [IDX_W-1:0]  got_i [NUM_DEV];

  always @(negedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      check(1'b0, "watchdog", 64'(cyc), 64'(WD_LIMIT));
      summary();
      $finish;
    end
    if (cnv && !prev_cnv) begin
      cnv_rises++;
      rises = 0; cnv_hi = 0; lat = 0; stall_cnt = 0; slot = 0;
    end
    if (sck && !prev_sck) begin
      rises++;
      if (!cnv) bad_sck++;
    end
    if (cnv) cnv_hi++;
    if (cnv && !sck && rises == 0) lat++;
    prev_sck = sck;
    prev_cnv = cnv;

    case (mode)
      2'd0: rdy = 1'b1;
      2'd1: rdy = (cyc % 3 == 0);
      2'd2: begin
        if (wvalid && widx == 0 && stall_cnt < STALL) begin
          rdy = 1'b0;
          stall_cnt++;
          if (stall_cnt == STALL) begin
            // R6: clock parked high before the falling edge that ends word 1
            check(rises == 2 * WORD_W, "R6 rises while stalled", 64'(rises), 64'(2 * WORD_W));
            check(sck == 1'b1, "R6 sck held high", 64'(sck), 64'd1);
            check(wdata == model_words[TOTAL-1 -: WORD_W], "R6 waiting data",
                  64'(wdata), 64'(model_words[TOTAL-1 -: WORD_W]));
          end
        end else begin
          rdy = 1'b1;
        end
      end
      default: rdy = !(wvalid && widx == IDX_W'(NUM_DEV - 1)) || rel;
    endcase

    if (wvalid && rdy && slot < NUM_DEV) begin
      got_d[slot] = wdata;
      got_i[slot] = widx;
      slot++;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_txn(input logic [TOTAL-1:0] words, input logic [1:0] m,
                         input bit second_start, input bit hold_last);
    int cr0;
    model_words = words;
    mode = m;
    rel = 1'b0;
    cr0 = cnv_rises;
    pulse_start();
    check(busy && cnv && !sck, "R2 start response", {61'd0, busy, cnv, sck}, 64'b110);
    if (second_start) begin
      repeat (100) @(negedge clk);
      pulse_start();
    end
    if (hold_last) begin
      @(negedge cnv);
      repeat (20) @(negedge clk);
      // R7: link quiet but busy held while last word waits
      check(busy && wvalid && !cnv && !sck && widx == IDX_W'(NUM_DEV - 1),
            "R7 busy until last word taken", {59'd0, busy, wvalid, cnv, sck, 1'b0},
            64'b11000);
      rel = 1'b1;
    end
    wait (!busy);
    repeat (10) @(negedge clk);
    for (int k = 0; k < NUM_DEV; k++) begin
      logic [WORD_W-1:0] e;
      e = words[TOTAL-1-k*WORD_W -: WORD_W];
      check(got_d[k] == e, "R5 word data", 64'(got_d[k]), 64'(e));
      check(got_i[k] == IDX_W'(k), "R5 word index", 64'(got_i[k]), 64'(k));
    end
    check(slot == NUM_DEV, "R7 words delivered", 64'(slot), 64'(NUM_DEV));
    check(rises == TOTAL, "R4 clock count", 64'(rises), 64'(TOTAL));
    check(bad_sck == 0, "R4 clock outside window", 64'(bad_sck), 64'd0);
    check(lat == CONV_CYC + SCK_DIV, "R3 conversion wait", 64'(lat), 64'(CONV_CYC + SCK_DIV));
    if (m == 2'd0)
      check(cnv_hi == CONV_CYC + 2 * SCK_DIV * TOTAL, "R3 convert window length",
            64'(cnv_hi), 64'(CONV_CYC + 2 * SCK_DIV * TOTAL));
    check(!cnv && !sck && !busy, "R7 idle after transaction", {61'd0, cnv, sck, busy}, 64'd0);
    check(cnv_rises - cr0 == 1, "R8 single convert pulse", 64'(cnv_rises - cr0), 64'd1);
    check(bad_start == 0, "R2 sck low at convert rise", 64'(bad_start), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !cnv && !sck && !wvalid, "R1 reset state",
          {60'd0, busy, cnv, sck, wvalid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cnv && !sck && !wvalid, "R1 after reset release",
          {60'd0, busy, cnv, sck, wvalid}, 64'd0);

    for (int v = 0; v < 4; v++)
      run_txn(VECS[v].words, VECS[v].mode, 1'b0, 1'b0);

    // R8: second start in the middle of shifting
    run_txn(48'h1357_9BDF_2468, 2'd0, 1'b1, 1'b0);
    // R7: last word held back by the consumer
    run_txn(48'hFEDC_BA98_7654, 2'd3, 1'b0, 1'b1);

    summary();
    $finish;
  end
endmodule